// File: doc/BRIEF.md
# Static Branch Direction Predictor with Dynamic Fallback

This block sits in the fetch or decode stage of a pipeline. For each conditional branch it takes the branch's own address, its decoded target, a two-bit compiler hint, and the opinion of a dynamic predictor. From these it produces a registered taken/not-taken prediction and the address to fetch next.

When the dynamic predictor says it has usable history, the prediction follows that predictor. When it says it has no usable history, the block falls back to its own static answer. The static answer is decided in this order:

1. A hint in the instruction wins.
2. Without a hint, the configured rule applies:
   - in the simple mode, every branch is predicted not taken;
   - in the direction mode, a branch that jumps to a lower address is predicted taken, and any other branch is predicted not taken.

Top module: `static_bp`

## Requirements
- R1: While rst_n is low, and after it is released until the first valid strobe, pred_vld, pred_taken and pred_next are all 0.
- R2: pred_vld equals the value req_vld had one clock edge earlier.
- R3: With dyn_hit=0, mode_dir=0 and no forcing hint, the prediction is not taken, for any pair of addresses.
- R4: With dyn_hit=0, mode_dir=1 and no forcing hint, a target that is below br_pc (unsigned, full width) gives taken.
- R5: With dyn_hit=0, mode_dir=1 and no forcing hint, a target that is equal to or above br_pc gives not taken. A target equal to br_pc counts here.
- R6: With dyn_hit=0, hint 2'b10 forces taken and hint 2'b01 forces not taken, in either mode and for either direction.
- R7: Hint 2'b00 (none) and hint 2'b11 (reserved) do not force anything; the mode rule decides.
- R8: With dyn_hit=1, pred_taken equals dyn_taken, whatever the hint, mode or addresses.
- R9: pred_next is br_tgt when the prediction is taken. Otherwise it is br_pc + INSN_BYTES, modulo 2^AW.
- R10: When req_vld is 0, pred_taken and pred_next keep the values they had.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | A branch is presented this cycle |
| br_pc | input | AW | Address of the branch |
| br_tgt | input | AW | Decoded target address |
| br_hint | input | 2 | 00 none, 01 not taken, 10 taken, 11 reserved (treated as none) |
| mode_dir | input | 1 | 0: always not taken; 1: backward taken, forward not taken |
| dyn_hit | input | 1 | The dynamic predictor has usable information |
| dyn_taken | input | 1 | The dynamic predictor's direction |
| pred_vld | output | 1 | The prediction below is new this cycle |
| pred_taken | output | 1 | Predicted direction |
| pred_next | output | AW | Predicted next fetch address |

## Verification
Every result appears exactly one clock edge after the strobe that carries it. This holds for the valid flag, the direction and the next address alike; nothing is combinational from input to output.

The bench drives each vector on a falling edge. It then waits one rising edge and compares at the following falling edge. By then the register has taken the vector, and the next vector has not yet been applied.

Cycles without a strobe are checked the same way, against the value the bench model held over. This shows that nothing moved.

// File: rtl/static_bp_pkg.sv
package static_bp_pkg;

    typedef enum logic [1:0] {
        HINT_NONE = 2'b00,
        HINT_NT   = 2'b01,
        HINT_T    = 2'b10,
        HINT_RSV  = 2'b11
    } hint_e;

endpackage

// File: rtl/sbp_static_dir.sv
module sbp_static_dir
    import static_bp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          mode_dir,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] tgt,
    input  logic [1:0]    hint,
    output logic          stat_taken
);

    logic backward;

    // Unsigned compare over the full width; equal counts as forward.
    assign backward = (tgt < pc);

    always_comb begin
        if (hint == HINT_T) begin
            stat_taken = 1'b1;
        end else if (hint == HINT_NT) begin
            stat_taken = 1'b0;
        end else if (mode_dir) begin
            stat_taken = backward;
        end else begin
            stat_taken = 1'b0;
        end
    end

endmodule

// File: rtl/sbp_next_sel.sv
module sbp_next_sel #(
    parameter int AW         = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic          taken,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] tgt,
    output logic [AW-1:0] next_pc
);

    localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

    logic [AW-1:0] fall_thru;

    assign fall_thru = pc + STEP;
    assign next_pc   = taken ? tgt : fall_thru;

endmodule

// File: rtl/static_bp.sv
module static_bp
    import static_bp_pkg::*;
#(
    parameter int AW         = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_vld,
    input  logic [AW-1:0] br_pc,
    input  logic [AW-1:0] br_tgt,
    input  logic [1:0]    br_hint,
    input  logic          mode_dir,
    input  logic          dyn_hit,
    input  logic          dyn_taken,
    output logic          pred_vld,
    output logic          pred_taken,
    output logic [AW-1:0] pred_next
);

    typedef struct packed {
        logic          vld;
        logic          taken;
        logic [AW-1:0] next;
    } pred_t;

    pred_t         st_d, st_q;
    logic          stat_taken;
    logic          final_taken;
    logic [AW-1:0] next_pc;

    sbp_static_dir #(.AW(AW)) u_dir (
        .mode_dir   (mode_dir),
        .pc         (br_pc),
        .tgt        (br_tgt),
        .hint       (br_hint),
        .stat_taken (stat_taken)
    );

    // The dynamic answer wins whenever it is usable.
    assign final_taken = dyn_hit ? dyn_taken : stat_taken;

    sbp_next_sel #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_sel (
        .taken   (final_taken),
        .pc      (br_pc),
        .tgt     (br_tgt),
        .next_pc (next_pc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_vld;
        if (req_vld) begin
            st_d.taken = final_taken;
            st_d.next  = next_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pred_vld   = st_q.vld;
    assign pred_taken = st_q.taken;
    assign pred_next  = st_q.next;

    localparam logic [AW-1:0] STEP_CHK = AW'(INSN_BYTES);

    AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> pred_vld);                                        // R2
    AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !pred_vld);                                      // R2
    AST_DYN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && dyn_hit) |=> (pred_taken == $past(dyn_taken)));   // R8
    AST_HINT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !dyn_hit && br_hint == HINT_T) |=> pred_taken);   // R6
    AST_NEXT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> (pred_next == (pred_taken ? $past(br_tgt)
                                              : $past(br_pc) + STEP_CHK))); // R9
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> ($stable(pred_taken) && $stable(pred_next)));    // R10

endmodule

// File: tb/sim_static_bp.sv
`timescale 1ns/1ps
module sim_static_bp;

    localparam int AW = 32;
    localparam int IB = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_vld;
    logic [AW-1:0] br_pc;
    logic [AW-1:0] br_tgt;
    logic [1:0]    br_hint;
    logic          mode_dir;
    logic          dyn_hit;
    logic          dyn_taken;
    logic          pred_vld;
    logic          pred_taken;
    logic [AW-1:0] pred_next;

    int n_vec  = 0;
    int n_fail = 0;
    logic          m_taken;
    logic [AW-1:0] m_next;
    bit            done = 0;

    always #5 clk = ~clk;

    static_bp #(.AW(AW), .INSN_BYTES(IB)) u0 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .br_pc(br_pc),
        .br_tgt(br_tgt), .br_hint(br_hint), .mode_dir(mode_dir),
        .dyn_hit(dyn_hit), .dyn_taken(dyn_taken), .pred_vld(pred_vld),
        .pred_taken(pred_taken), .pred_next(pred_next)
    );

    function automatic logic exp_taken(logic [AW-1:0] pc, logic [AW-1:0] tg,
                                       logic [1:0] h, logic md, logic dh, logic dt);
        if (dh) return dt;
        if (h == 2'b10) return 1'b1;
        if (h == 2'b01) return 1'b0;
        if (!md) return 1'b0;
        return (tg < pc);
    endfunction

    function automatic string tag_of(logic [AW-1:0] pc, logic [AW-1:0] tg,
                                     logic [1:0] h, logic md, logic dh);
        if (dh) return "R8";
        if (h == 2'b10 || h == 2'b01) return "R6";
        if (h == 2'b11) return "R7";
        if (!md) return "R3";
        if (tg < pc) return "R4";
        return "R5";
    endfunction

    task automatic check(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Entered on a falling edge; leaves on the falling edge after the result is due.
    task automatic apply(logic v, logic [AW-1:0] pc, logic [AW-1:0] tg,
                         logic [1:0] h, logic md, logic dh, logic dt);
        string t;
        req_vld = v; br_pc = pc; br_tgt = tg; br_hint = h;
        mode_dir = md; dyn_hit = dh; dyn_taken = dt;
        t = tag_of(pc, tg, h, md, dh);
        if (v) begin
            m_taken = exp_taken(pc, tg, h, md, dh, dt);
            m_next  = m_taken ? tg : pc + AW'(IB);
        end
        @(posedge clk);
        @(negedge clk);
        check("R2", "vld", AW'(pred_vld), AW'(v));
        if (v) begin
            check(t, "taken", AW'(pred_taken), AW'(m_taken));
            check("R9", "next", pred_next, m_next);
        end else begin
            check("R10", "taken held", AW'(pred_taken), AW'(m_taken));
            check("R10", "next held", pred_next, m_next);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; req_vld = 0; br_pc = '0; br_tgt = '0; br_hint = 2'b00;
        mode_dir = 0; dyn_hit = 0; dyn_taken = 0;
        m_taken = 0; m_next = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "vld", AW'(pred_vld), '0);
        check("R1", "taken", AW'(pred_taken), '0);
        check("R1", "next", pred_next, '0);
        rst_n = 1;
        @(negedge clk);
        check("R1", "next after release", pred_next, '0);

        // Directed corner cases
        apply(1, 32'h1000, 32'h0F00, 2'b00, 0, 0, 0);  // R3 backward, simple mode
        apply(1, 32'h1000, 32'h0F00, 2'b00, 1, 0, 0);  // R4
        apply(1, 32'h1000, 32'h1000, 2'b00, 1, 0, 0);  // R5 equal
        apply(1, 32'h1000, 32'h2000, 2'b00, 1, 0, 0);  // R5 forward
        apply(1, 32'h1000, 32'h2000, 2'b10, 0, 0, 0);  // R6 forced taken
        apply(1, 32'h1000, 32'h0100, 2'b01, 1, 0, 0);  // R6 forced not taken
        apply(1, 32'h1000, 32'h0100, 2'b11, 1, 0, 0);  // R7 reserved
        apply(1, 32'h1000, 32'h0100, 2'b11, 0, 0, 0);  // R7 reserved, simple
        apply(1, 32'h1000, 32'h0100, 2'b10, 1, 1, 0);  // R8 dyn overrides
        apply(1, 32'h1000, 32'h2000, 2'b01, 0, 1, 1);  // R8
        apply(1, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 2'b00, 1, 0, 0); // R9 wrap
        apply(0, 32'h5, 32'h1, 2'b10, 1, 0, 0);        // R10 idle
        apply(0, 32'h9, 32'h3, 2'b00, 1, 1, 1);        // R10 idle

        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] pc, tg;
            pc = $urandom();
            tg = ($urandom_range(0, 7) == 0) ? pc : $urandom();
            apply(($urandom_range(0, 3) != 0), pc, tg, 2'($urandom_range(0, 3)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0),
                  1'($urandom_range(0, 1)));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule